// File: doc/BRIEF.md
# Stochastic Stream Rescaler

This block removes a power-of-two gain from a serial stochastic bit stream without converting it back to binary. Operands are often shifted left before stream generation, because a stream that encodes a larger value carries less relative noise. The product stream then has a ones-density that is too large by 2^k. Here k is the sum of the two operand shift amounts. The rescaler thins that stream: it counts incoming ones and emits a single one each time the count reaches 2^k. This lowers the density by exactly that factor, one output bit for every input bit.

A new stream begins with a load strobe that carries both operand exponents. The block adds them, turns the sum into a one-hot factor, and clears the ones counter. Each later valid input bit moves the count forward. An equality test built from bitwise XNOR compares the count with the factor. A match produces an output one and wraps the counter to zero. Bits offered without the valid strobe are ignored. Each output bit is registered and appears one cycle after its input, together with its own valid flag.

Top module: `rsc_stream_rescaler`

## Requirements
- R1: While reset is held, and after it is released, both outputs are 0. The ones counter starts at zero. The factor starts at 1, which is an effective exponent of 0.
- R2: out_valid_o equals in_valid_i delayed by exactly one clock cycle. Every valid input bit yields exactly one output bit.
- R3: A cycle with load_i high sets the effective exponent k to the unsigned sum exp_a_i + exp_b_i. The factor 2^k then holds until the next load.
- R4: out_bit_o is 1 one cycle after the valid input bit that brings the number of valid ones since the last load or match to 2^k. It is 0 for every other valid bit. The counter then restarts from zero, so exactly one output one appears per 2^k input ones.
- R5: With k = 0 the output stream equals the input stream, delayed by one cycle.
- R6: A load discards any partial count. Ones counted before the load do not add toward the next output one.
- R7: When load_i and in_valid_i are high in the same cycle, the counter is cleared first. That cycle's bit is then counted against the newly loaded factor.
- R8: An input bit offered while in_valid_i is low does not change the count and produces no output bit. The next cycle shows out_valid_o = 0 and out_bit_o = 0.
- R9: out_bit_o is never 1 while out_valid_o is 0.
- R10: The largest exponent sum, 2*(2^EXP_W - 1), which is 14 by default, works without counter overflow. The first output one appears exactly at the 2^14-th input one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Starts a new stream: loads the exponents and clears the count |
| exp_a_i | input | EXP_W | Shift exponent of the first operand |
| exp_b_i | input | EXP_W | Shift exponent of the second operand |
| in_valid_i | input | 1 | Qualifies in_bit_i |
| in_bit_i | input | 1 | Incoming stochastic stream bit |
| out_valid_o | output | 1 | Qualifies out_bit_o, one cycle after in_valid_i |
| out_bit_o | output | 1 | Rescaled stochastic stream bit |

## Verification
Two functions can fall in the same cycle: loading a new factor, which clears the count, and counting a valid bit. The bench forces this case. It drives load_i together with a valid one while the counter holds a partial count. It also reloads during idle cycles and in the middle of a stream. A reference model, built from the requirements, decides for each cycle whether that bit belongs to the new stream. A scoreboard compares every output cycle against this model. As a result, a design that counts the coincident bit before clearing, or that compares it against the old factor, misplaces an output one, and the scoreboard reports it.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  // Default width of each operand exponent
  localparam int DEF_EXP_W = 3;

  // Largest combined shift when both operands use their widest exponent
  function automatic int max_shift(input int exp_w);
    return 2 * ((1 << exp_w) - 1);
  endfunction

  // Bits needed to hold a one-hot factor up to 2^max_shift
  function automatic int factor_width(input int exp_w);
    return max_shift(exp_w) + 1;
  endfunction

endpackage

// File: rtl/rsc_rst_sync.sv
module rsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/rsc_factor_sel.sv
module rsc_factor_sel
  import rsc_pkg::*;
#(
  parameter int EXP_W = DEF_EXP_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load,
  input  logic [EXP_W-1:0]                  exp_a,
  input  logic [EXP_W-1:0]                  exp_b,
  output logic [factor_width(EXP_W)-1:0]    factor_o
);

  localparam int SUM_W = EXP_W + 1;
  localparam int MAX_K = max_shift(EXP_W);
  localparam int FAC_W = factor_width(EXP_W);

  logic [SUM_W-1:0] shift_sum;
  logic [FAC_W-1:0] decoded;
  logic [FAC_W-1:0] factor_q;
  logic [FAC_W-1:0] factor_d;
  logic             factor_en;

  // Combined exponent of the two scaled operands
  always_comb begin
    shift_sum = {1'b0, exp_a} + {1'b0, exp_b};
  end

  // Exponent to one-hot factor decode
  for (genvar i = 0; i <= MAX_K; i++) begin : g_dec
    assign decoded[i] = (shift_sum == SUM_W'(i));
  end

  // Next-state: a load takes effect in its own cycle
  always_comb begin
    factor_en = load;
    factor_d  = load ? decoded : factor_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      factor_q <= FAC_W'(1);
    end else if (factor_en) begin
      factor_q <= factor_d;
    end
  end

  assign factor_o = factor_d;

  // R3: the stored factor is always a single power of two
  p_factor_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(factor_q) == 1)
    else $error("stored factor is not one-hot");

  // R3: factor only moves on a load
  p_factor_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(factor_q))
    else $error("factor changed without a load");

endmodule

// File: rtl/rsc_pulse_thinner.sv
module rsc_pulse_thinner #(
  parameter int FAC_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_i,
  input  logic [FAC_W-1:0] factor,
  output logic             hit_o
);

  logic [FAC_W-1:0] cnt_q;
  logic [FAC_W-1:0] cnt_d;
  logic [FAC_W-1:0] cnt_base;
  logic [FAC_W-1:0] cnt_sum;
  logic [FAC_W-1:0] eq_vec;
  logic             match;
  logic             cnt_en;

  // Clear has priority, then the incoming bit is added
  always_comb begin
    cnt_base = clr ? '0 : cnt_q;
    cnt_sum  = cnt_base + FAC_W'(bit_i);
  end

  // Equality through bitwise XNOR and an AND reduction
  for (genvar i = 0; i < FAC_W; i++) begin : g_xnor
    assign eq_vec[i] = ~(cnt_sum[i] ^ factor[i]);
  end

  always_comb begin
    match  = &eq_vec;
    hit_o  = en & match;
    cnt_en = en | clr;
    if (en) begin
      cnt_d = match ? '0 : cnt_sum;
    end else begin
      cnt_d = cnt_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R4: the held count never reaches the factor that governs it
  p_cnt_below_factor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (cnt_q < factor))
    else $error("count reached factor without wrapping");

  // R4: an output one is only produced by an incoming one
  p_hit_needs_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> bit_i)
    else $error("hit without an incoming one");

  // R8: idle cycles leave the count untouched
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt_q))
    else $error("count moved on an idle cycle");

  // R6: a load without a bit leaves a cleared count
  p_load_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !en) |=> (cnt_q == '0))
    else $error("load did not clear the count");

endmodule

// File: rtl/rsc_out_stage.sv
module rsc_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hit,
  output logic out_valid_o,
  output logic out_bit_o
);

  logic valid_q;
  logic valid_d;
  logic bit_q;
  logic bit_d;
  logic bit_en;

  always_comb begin
    valid_d = en;
    bit_en  = en | bit_q;
    bit_d   = en & hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
    end else if (bit_en) begin
      bit_q <= bit_d;
    end
  end

  assign out_valid_o = valid_q;
  assign out_bit_o   = bit_q;

  // R9: no one bit outside a valid output cycle
  p_quiet_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid_o |-> !out_bit_o)
    else $error("output one without valid");

  // R2: output valid follows input valid by one cycle
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> out_valid_o)
    else $error("missing output for a valid input");

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out_valid_o)
    else $error("output valid without an input");

endmodule

// File: rtl/rsc_stream_rescaler.sv
module rsc_stream_rescaler
  import rsc_pkg::*;
#(
  parameter int EXP_W = DEF_EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [EXP_W-1:0] exp_a_i,
  input  logic [EXP_W-1:0] exp_b_i,
  input  logic             in_valid_i,
  input  logic             in_bit_i,
  output logic             out_valid_o,
  output logic             out_bit_o
);

  localparam int FAC_W = factor_width(EXP_W);

  logic             rst_n_sync;
  logic [FAC_W-1:0] factor;
  logic             hit;

  rsc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  rsc_factor_sel #(.EXP_W(EXP_W)) u_factor (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load     (load_i),
    .exp_a    (exp_a_i),
    .exp_b    (exp_b_i),
    .factor_o (factor)
  );

  rsc_pulse_thinner #(.FAC_W(FAC_W)) u_thinner (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .clr    (load_i),
    .en     (in_valid_i),
    .bit_i  (in_bit_i),
    .factor (factor),
    .hit_o  (hit)
  );

  rsc_out_stage u_out (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .en          (in_valid_i),
    .hit         (hit),
    .out_valid_o (out_valid_o),
    .out_bit_o   (out_bit_o)
  );

  // R5: with a unit factor every valid bit passes straight through
  p_passthru_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid_i && factor == FAC_W'(1)) |=> (out_bit_o == $past(in_bit_i)))
    else $error("unit factor did not pass the stream through");

endmodule

// File: tb/rsc_stream_rescaler_bench.sv
`timescale 1ns/1ps
module rsc_stream_rescaler_bench;

  localparam int EXP_W = 3;

  typedef struct {
    logic  v;
    logic  b;
    string tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             load;
  logic [EXP_W-1:0] exp_a;
  logic [EXP_W-1:0] exp_b;
  logic             in_valid;
  logic             in_bit;
  logic             out_valid;
  logic             out_bit;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  int   m_k    = 0;
  int   m_cnt  = 0;

  always #2 clk = ~clk;

  rsc_stream_rescaler #(.EXP_W(EXP_W)) u_rsc_stream_rescaler (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .exp_a_i     (exp_a),
    .exp_b_i     (exp_b),
    .in_valid_i  (in_valid),
    .in_bit_i    (in_bit),
    .out_valid_o (out_valid),
    .out_bit_o   (out_bit)
  );

  task automatic chk(input string tag, input logic av, input logic ab,
                     input logic ev, input logic eb);
    checks++;
    if (av !== ev || ab !== eb) begin
      errors++;
      $display("FAIL %s: valid/bit got %b/%b expected %b/%b at %0t",
               tag, av, ab, ev, eb, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected output
  task automatic drive(input bit ld, input int ea, input int eb,
                       input bit v, input bit b, input string tag);
    exp_t e;
    @(negedge clk);
    load     = ld;
    exp_a    = EXP_W'(ea);
    exp_b    = EXP_W'(eb);
    in_valid = v;
    in_bit   = b;
    if (ld) begin
      m_k   = ea + eb;
      m_cnt = 0;
    end
    e.v   = v;
    e.b   = 1'b0;
    e.tag = tag;
    if (v) begin
      m_cnt += int'(b);
      if (m_cnt == (1 << m_k)) begin
        e.b   = 1'b1;
        m_cnt = 0;
      end
    end
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 1, tag);
  endtask

  // Monitor: compares each registered output against the queue
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, out_valid, out_bit, e.v, e.b);
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ones_out;
    rst_n    = 1'b0;
    load     = 1'b0;
    exp_a    = '0;
    exp_b    = '0;
    in_valid = 1'b1;
    in_bit   = 1'b1;
    #10;
    chk("R1 reset", out_valid, out_bit, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1 reset held", out_valid, out_bit, 1'b0, 1'b0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 after release", out_valid, out_bit, 1'b0, 1'b0);

    // R1/R5: default factor passes the stream through
    drive(0, 0, 0, 1, 1, "R1 default factor");
    drive(0, 0, 0, 1, 0, "R5 passthrough");
    drive(0, 0, 0, 1, 1, "R5 passthrough");
    drive(0, 0, 0, 1, 1, "R5 passthrough");
    idle(2, "R2 idle");

    // R3/R4: exponents 1+1 give k=2, one out per four ones
    drive(1, 1, 1, 0, 0, "R3 load");
    for (int i = 0; i < 12; i++) drive(0, 0, 0, 1, 1, "R4 thin by 4");
    for (int i = 0; i < 8; i++) drive(0, 0, 0, 1, (i % 3) == 0, "R4 mixed");

    // R8: invalid bits interleaved
    for (int i = 0; i < 10; i++) drive(0, 0, 0, i % 2, 1, "R8 gated");

    // R6: load mid-stream discards partial count
    drive(1, 2, 0, 1, 1, "R7 load with bit");
    drive(0, 0, 0, 1, 1, "R6 partial");
    drive(1, 1, 0, 0, 1, "R6 reload");
    drive(0, 0, 0, 1, 1, "R6 after reload");
    drive(0, 0, 0, 1, 1, "R6 after reload");
    drive(0, 0, 0, 1, 1, "R6 after reload");

    // R7: load with a valid one over a partial count
    drive(1, 0, 1, 1, 1, "R7 coincident");
    drive(0, 0, 0, 1, 1, "R7 coincident next");
    drive(0, 0, 0, 1, 1, "R7 partial");
    drive(1, 1, 0, 1, 1, "R7 coincident over partial");
    drive(0, 0, 0, 1, 1, "R7 new factor");
    drive(1, 0, 0, 1, 1, "R7 coincident unit");

    // R5: reload exponent 0 after a larger factor
    drive(1, 3, 3, 1, 1, "R3 large");
    drive(1, 0, 0, 0, 0, "R5 reload unit");
    for (int i = 0; i < 6; i++) drive(0, 0, 0, 1, (i % 2) == 1, "R5 passthrough");

    // R2/R4: random stream with k=3
    drive(1, 2, 1, 0, 0, "R3 load k3");
    for (int i = 0; i < 400; i++)
      drive(0, 0, 0, ($urandom % 4) != 0, $urandom % 2, "R4 random");
    idle(3, "R2 idle");

    // R10: largest exponent sum
    drive(1, 7, 7, 0, 0, "R10 load max");
    for (int i = 0; i < (1 << 14) + 4; i++) drive(0, 0, 0, 1, 1, "R10 max factor");
    idle(3, "R10 idle");
    ones_out = 0;

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule